// File: doc/BRIEF.md
# Paced Random Word Generator with Refill Handshake

This block is a register-mapped controller for a true random number generator. Once software sets the enable bit, the block takes a programmed number of startup samples, then presents a 64-bit random word and raises a ready flag. Software reads the word as two 32-bit halves and acknowledges it. The acknowledge clears ready and opens a refill window of further samples before the next word appears. A programmable divider spaces the samples in input clock cycles.

The physical noise source is replaced by a 64-bit linear feedback shift register. It loads from a seed port while the generator is disabled, which makes every output word predictable in test. Each sample-count field is an 8-bit value scaled by a power of two. A field of zero selects the largest window, 2^ZERO_LOG2 samples. A single interrupt output is the ready flag gated by a mask bit.

Top module: `rng_refill_ctrl`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. Word indices come from byte address bits [4:2]: 0 word low, 1 word high, 2 status, 3 mask, 4 acknowledge, 5 control, 6 config. A read with `bus_re` low returns zero.
- R2: Control bit 10 enables the generator, and control bits [23:16] hold the startup field S. The first ready flag appears N*(D+1) cycles after the enabling write, where N = S*2^SU_LOG2, or 2^ZERO_LOG2 when S is zero.
- R3: Config bits [15:8] hold the divider D. One sample is taken every D+1 clock cycles, and the pacing restarts at the start of each window.
- R4: The source steps once per sample as s' = {s[62:0], s[63]^s[62]^s[60]^s[59]}, starting from `seed` at enable. The presented word is the source state after the total number of samples taken since enable. Its bits [31:0] are at index 0 and bits [63:32] at index 1.
- R5: Writing a word with bit 0 set to the acknowledge register while ready is high clears ready in the cycle of the write and starts a refill window. A write with bit 0 clear, or any acknowledge while ready is low, has no effect.
- R6: The refill window lasts min(Nmin, Nmax) samples. Nmin = config[7:0]*2^MIN_LOG2 and Nmax = config[23:16]*2^MAX_LOG2, each replaced by 2^ZERO_LOG2 when its field is zero.
- R7: The output word registers keep their last value from the acknowledge until the next ready.
- R8: Mask register bit 0 gates the interrupt, so that `irq` = ready AND mask bit 0.
- R9: Writing control with bit 10 clear drops ready one cycle later and reloads the source from `seed`. The next enable performs a full startup window.
- R10: Status bit 0 reads the ready flag.
- R11: No sample is taken while ready is high, so the source state is frozen between a ready and its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| seed | input | 64 | Source seed, loaded while disabled |
| irq | output | 1 | Masked ready interrupt |

## Verification
Any internal fault shows at the ports in one of two ways. A wrong sample counter or divider moves the rise of `irq` away from its computed cycle, and the bench measures that cycle exactly. A source that steps during hold or misses a sample gives a word that differs from the arithmetic sequence computed from the seed, and this shows at the very next ready. The bench sweeps startup fields, dividers and refill pairs, including the zero encodings and the case where the maximum caps the minimum. In each case it checks the timing and both output words of two consecutive words.

// File: rtl/rng_pkg.sv
package rng_pkg;
   localparam int RNG_W = 64;
   localparam logic [RNG_W-1:0] RNG_TAPS = 64'hD800_0000_0000_0000;

   localparam logic [2:0] IDX_WORD_LO = 3'd0;
   localparam logic [2:0] IDX_WORD_HI = 3'd1;
   localparam logic [2:0] IDX_STATUS  = 3'd2;
   localparam logic [2:0] IDX_MASK    = 3'd3;
   localparam logic [2:0] IDX_ACK     = 3'd4;
   localparam logic [2:0] IDX_CTRL    = 3'd5;
   localparam logic [2:0] IDX_CONFIG  = 3'd6;

   localparam int CTRL_EN_BIT   = 10;
   localparam int CTRL_SU_LSB   = 16;
   localparam int CFG_MIN_LSB   = 0;
   localparam int CFG_DIV_LSB   = 8;
   localparam int CFG_MAX_LSB   = 16;

   typedef enum logic [0:0] {
      PH_STARTUP = 1'b0,
      PH_REFILL  = 1'b1
   } rng_phase_e;
endpackage

// File: rtl/rng_pacer.sv
module rng_pacer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!run)       cnt_q <= '0;
      else if (cnt_q >= div) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
   end

   assign tick = run && (cnt_q >= div);
endmodule

// File: rtl/rng_source.sv
module rng_source #(
   parameter int              W    = 64,
   parameter logic [W-1:0]    TAPS = 64'hD800_0000_0000_0000
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] seed,
   output logic [W-1:0] next_state
);
   logic [W-1:0] state_q;

   initial begin
      seed_width_chk: assert (W >= 2);
   end

   assign next_state = {state_q[W-2:0], ^(state_q & TAPS)};

   always_ff @(posedge clk) begin
      if (!rst_n)     state_q <= '0;
      else if (load)  state_q <= seed;
      else if (step)  state_q <= next_state;
   end
endmodule

// File: rtl/rng_sampler.sv
module rng_sampler
   import rng_pkg::*;
#(
   parameter int CNT_W = 25,
   parameter int W     = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             ack,
   input  logic [CNT_W-1:0] startup_n,
   input  logic [CNT_W-1:0] refill_n,
   input  logic [W-1:0]     src_next,
   output logic             ready,
   output logic [W-1:0]     word
);
   rng_phase_e       phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] target;
   logic [CNT_W-1:0] cnt_inc;

   assign target  = (phase_q == PH_STARTUP) ? startup_n : refill_n;
   assign cnt_inc = cnt_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_STARTUP;
         cnt_q   <= '0;
         ready   <= 1'b0;
         word    <= '0;
      end else if (!en) begin
         phase_q <= PH_STARTUP;
         cnt_q   <= '0;
         ready   <= 1'b0;
      end else if (ready) begin
         if (ack) begin
            ready   <= 1'b0;
            phase_q <= PH_REFILL;
            cnt_q   <= '0;
         end
      end else if (tick) begin
         if (cnt_inc >= target) begin
            ready <= 1'b1;
            word  <= src_next;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_inc;
         end
      end
   end

   // R5
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && ack && en) |=> !ready);
   // R5
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !ack && en) |=> ready);
   // R9
   disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !ready);
   // R7
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(word));
endmodule

// File: rtl/rng_refill_ctrl.sv
module rng_refill_ctrl
   import rng_pkg::*;
#(
   parameter int FIELD_W   = 8,
   parameter int ZERO_LOG2 = 24,
   parameter int SU_LOG2   = 8,
   parameter int MIN_LOG2  = 6,
   parameter int MAX_LOG2  = 8,
   parameter int ADDR_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [63:0]       seed,
   output logic              irq
);
   localparam int UNIT_MAX = (SU_LOG2 > MIN_LOG2) ?
                             ((SU_LOG2 > MAX_LOG2) ? SU_LOG2 : MAX_LOG2) :
                             ((MIN_LOG2 > MAX_LOG2) ? MIN_LOG2 : MAX_LOG2);
   localparam int SPAN_W   = FIELD_W + UNIT_MAX;
   localparam int CNT_W    = ((ZERO_LOG2 > SPAN_W) ? ZERO_LOG2 : SPAN_W) + 1;

   initial begin
      field_width_chk: assert (FIELD_W >= 1 && FIELD_W <= 8);
      addr_width_chk:  assert (ADDR_W >= 5);
      zero_enc_chk:    assert (ZERO_LOG2 >= 1);
   end

   function automatic logic [CNT_W-1:0] decode_n(input logic [FIELD_W-1:0] f,
                                                  input int unit_log2);
      if (f == '0) decode_n = CNT_W'(1) << ZERO_LOG2;
      else         decode_n = CNT_W'(f) << unit_log2;
   endfunction

   logic               en_q;
   logic [FIELD_W-1:0] su_q, min_q, div_q, max_q;
   logic               mask_q;
   logic [2:0]         idx;
   logic               ack;
   logic               ready;
   logic               tick;
   logic [RNG_W-1:0]   src_next;
   logic [RNG_W-1:0]   word;
   logic [CNT_W-1:0]   startup_n, min_n, max_n, refill_n;
   logic               unused_bits;

   assign idx = bus_addr[4:2];
   assign ack = bus_we && (idx == IDX_ACK) && bus_wdata[0];
   assign unused_bits = ^{bus_addr, bus_wdata};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         su_q   <= '0;
         min_q  <= '0;
         div_q  <= '0;
         max_q  <= '0;
         mask_q <= 1'b0;
      end else if (bus_we) begin
         case (idx)
            IDX_CTRL: begin
               en_q <= bus_wdata[CTRL_EN_BIT];
               su_q <= bus_wdata[CTRL_SU_LSB +: FIELD_W];
            end
            IDX_CONFIG: begin
               min_q <= bus_wdata[CFG_MIN_LSB +: FIELD_W];
               div_q <= bus_wdata[CFG_DIV_LSB +: FIELD_W];
               max_q <= bus_wdata[CFG_MAX_LSB +: FIELD_W];
            end
            IDX_MASK: mask_q <= bus_wdata[0];
            default: ;
         endcase
      end
   end

   assign startup_n = decode_n(su_q, SU_LOG2);
   assign min_n     = decode_n(min_q, MIN_LOG2);
   assign max_n     = decode_n(max_q, MAX_LOG2);
   assign refill_n  = (min_n <= max_n) ? min_n : max_n;

   rng_pacer #(.DIV_W(FIELD_W)) u_pacer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (en_q && !ready),
      .div  (div_q),
      .tick (tick)
   );

   rng_source #(.W(RNG_W), .TAPS(RNG_TAPS)) u_source (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (!en_q),
      .step      (tick),
      .seed      (seed),
      .next_state(src_next)
   );

   rng_sampler #(.CNT_W(CNT_W), .W(RNG_W)) u_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_q),
      .tick     (tick),
      .ack      (ack),
      .startup_n(startup_n),
      .refill_n (refill_n),
      .src_next (src_next),
      .ready    (ready),
      .word     (word)
   );

   logic [31:0] rd_words [0:7];
   always_comb begin
      for (int i = 0; i < 8; i++) rd_words[i] = '0;
      rd_words[IDX_WORD_LO] = word[31:0];
      rd_words[IDX_WORD_HI] = word[63:32];
      rd_words[IDX_STATUS][0] = ready;
      rd_words[IDX_MASK][0]   = mask_q;
      rd_words[IDX_CTRL][CTRL_EN_BIT] = en_q;
      rd_words[IDX_CTRL][CTRL_SU_LSB +: FIELD_W] = su_q;
      rd_words[IDX_CONFIG][CFG_MIN_LSB +: FIELD_W] = min_q;
      rd_words[IDX_CONFIG][CFG_DIV_LSB +: FIELD_W] = div_q;
      rd_words[IDX_CONFIG][CFG_MAX_LSB +: FIELD_W] = max_q;
   end

   assign bus_rdata = bus_re ? rd_words[idx] : 32'h0;
   assign irq       = ready && mask_q;

   // R11
   no_sample_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> !ready);
endmodule

// File: tb/rng_refill_ctrl_tb.sv
module rng_refill_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SU_L = 2, MIN_L = 1, MAX_L = 2, ZERO_L = 6;

   logic        clk = 0, rst_n = 0, bus_we = 0, bus_re = 0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [63:0] seed = '0;
   logic        irq;
   int checks = 0, failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rng_refill_ctrl #(.FIELD_W(8), .ZERO_LOG2(ZERO_L), .SU_LOG2(SU_L),
      .MIN_LOG2(MIN_L), .MAX_LOG2(MAX_L), .ADDR_W(5)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .seed(seed), .irq(irq));

   function automatic longint unsigned adv(longint unsigned s, int n);
      logic [63:0] v = s;
      for (int i = 0; i < n; i++) v = {v[62:0], v[63]^v[62]^v[60]^v[59]};
      return v;
   endfunction

   function automatic int dec(int f, int l);
      return (f == 0) ? (1 << ZERO_L) : (f << l);
   endfunction

   task automatic check(bit ok, string req, longint unsigned act, longint unsigned exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_we = 0;
   endtask

   task automatic rd(logic [4:0] a, output logic [31:0] d);
      bus_re = 1; bus_addr = a; #1; d = bus_rdata; bus_re = 0;
   endtask

   task automatic wait_irq(output int cyc);
      cyc = 0;
      while (!irq && cyc < 20000) begin @(negedge clk); cyc++; end
   endtask

   task automatic check_word(longint unsigned exp, string req);
      logic [31:0] lo, hi;
      rd(5'h00, lo); rd(5'h04, hi);
      check({hi, lo} == exp, req, {hi, lo}, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int cyc, run;
      int su_f [3] = '{0, 1, 3};
      int dv_f [2] = '{0, 2};
      int mn_f [4] = '{3, 5, 0, 2};
      int mx_f [4] = '{0, 1, 0, 2};
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset values
      for (int a = 0; a < 7; a++) begin
         rd(5'(a * 4), d);
         check(d == 0, "R1 reset read", d, 0);
      end
      check(irq == 0, "R1 irq reset", irq, 0);
      bus_addr = 5'h08; #1;
      check(bus_rdata == 0, "R1 read strobe low", bus_rdata, 0);
      wr(5'h0C, 32'h1);
      run = 0;
      foreach (su_f[s]) foreach (dv_f[v]) foreach (mn_f[m]) begin
         longint unsigned sd;
         int nsu, nref, dvv;
         dvv  = dv_f[v];
         nsu  = dec(su_f[s], SU_L);
         nref = dec(mn_f[m], MIN_L);
         if (dec(mx_f[m], MAX_L) < nref) nref = dec(mx_f[m], MAX_L);
         sd   = 64'h0123_4567_89AB_CDEF ^ (64'(run + 1) * 64'h9E37_79B9_7F4A_7C15);
         run++;
         seed = sd;
         wr(5'h18, (mx_f[m] << 16) | (dvv << 8) | mn_f[m]);
         wr(5'h14, (su_f[s] << 16) | (1 << 10));
         // R5: acknowledge while collecting is ignored
         wr(5'h10, 32'h1);
         wait_irq(cyc);
         // R2 R3: startup timing
         check(cyc + 2 == nsu * (dvv + 1), "R2 R3 startup cycles", cyc + 2, nsu * (dvv + 1));
         rd(5'h08, d);
         check(d == 1, "R10 status ready", d, 1);
         check_word(adv(sd, nsu), "R4 startup word");
         // R5: ack with bit0 clear has no effect
         wr(5'h10, 32'h2);
         repeat (2) @(negedge clk);
         check(irq == 1, "R5 ack bit0 clear ignored", irq, 1);
         // R8: mask gating
         wr(5'h0C, 32'h0);
         rd(5'h08, d);
         check(irq == 0 && d == 1, "R8 masked irq", irq, 0);
         wr(5'h0C, 32'h1);
         check(irq == 1, "R8 unmasked irq", irq, 1);
         wr(5'h10, 32'h1);
         check(irq == 0, "R5 ack clears ready", irq, 0);
         // R7: word holds during refill
         check_word(adv(sd, nsu), "R7 word holds");
         wait_irq(cyc);
         // R6 R11: refill timing and word
         check(cyc == nref * (dvv + 1), "R6 refill cycles", cyc, nref * (dvv + 1));
         check_word(adv(sd, nsu + nref), "R6 R11 refill word");
         // R9: disable clears ready
         wr(5'h14, 32'h0);
         @(negedge clk);
         rd(5'h08, d);
         check(d == 0, "R9 disable clears", d, 0);
      end
      // R9: re-enable restarts a full startup from the seed
      seed = 64'hFEDC_BA98_7654_3210;
      wr(5'h18, 32'h0000_0103);
      wr(5'h14, (1 << 16) | (1 << 10));
      wait_irq(cyc);
      check(cyc == 4 * 2, "R9 restart cycles", cyc, 8);
      check_word(adv(64'hFEDC_BA98_7654_3210, 4), "R9 restart word");
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule